// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a register-mapped interval timer. A narrow prescaler counts down on every clock. Each time it runs out, it reloads from a programmable divide value and steps a wide main counter down by one. When the main counter runs out, it reloads from a period register and sends a one-clock interrupt request to an external interrupt controller.

Software reaches three registers through a simple single-cycle register bus:

- The counter register can be read or overwritten directly.
- The period register holds the reload value for the main counter.
- The control register holds two fields: the divide value and the live prescaler count. A write to the control register may also restart both counters at once.

The reload rule is the same for both stages. A stage reloads when its count is 1 or 0. The interrupt interval is therefore max(divide,1) × max(period,1) clocks.

Top module: `pstimer`

## Requirements
- R1: After reset, the counter, period and control registers all read 0.
- R2: When no register is written, the prescaler count decrements by one on each clock while it is above 1. When it is 1 or 0, it reloads from the divide value, and that clock is a prescaler expiry.
- R3: On each prescaler expiry, the main counter decrements by one while it is above 1. When it is 1 or 0, it reloads from the period register. Between expiries the main counter holds its value.
- R4: The interrupt output is high for the single clock cycle that follows a main-counter reload, and low otherwise. In steady state the reloads are spaced max(D,1)·max(P,1) clocks apart, where D is the divide value and P is the period.
- R5: The counter is at address 0x24, the period at 0x25 and the control register at 0x26. A write to the counter or to the period replaces the stored value. The new value reads back in the next cycle.
- R6: The control register layout is as follows:
  - bits 3:0 hold the divide value (read/write);
  - bits 9:6 hold the live prescaler count (read/write);
  - bit 5 is the restart bit and always reads 0;
  - all other bits read 0.
  Reads from any other address return 0. Writes to any other address change nothing.
- R7: A control write with bit 5 set loads the main counter from the period register and the prescaler from the newly written divide value. No interrupt is raised for that cycle.
- R8: A register write takes priority over the countdown in the same cycle. A counter write stores the written value, with no reload and no interrupt in that cycle. A control write suppresses that cycle's prescaler expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register address, used for both read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Timer interrupt request pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 16-bit data and counter, and a 4-bit prescaler. It sweeps divide values 0 to 4 against period values 0 to 5. Every reload interval in that sweep stays within a few dozen clocks, so both the "count at 1" and the "count at 0" reload paths are reached in both stages. The bench also checks the first interrupt after a restart and the steady-state spacing for every pair. Short directed sequences cover the live prescaler field, the priority of a counter write over a pending reload, and writes to unmapped addresses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_PRD  = 2'd2,
    SEL_CTL  = 2'd3
  } tmr_sel_e;

  localparam int unsigned CTL_DIV_LSB = 0;
  localparam int unsigned CTL_RLD_BIT = 5;
  localparam int unsigned CTL_PSC_LSB = 6;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CNT_OFS = 'h24,
  parameter logic [ADDR_W-1:0] PRD_OFS = 'h25,
  parameter logic [ADDR_W-1:0] CTL_OFS = 'h26
) (
  input  logic [ADDR_W-1:0] addr,
  output tmr_pkg::tmr_sel_e sel
);
  always_comb begin
    if (addr == CNT_OFS)      sel = tmr_pkg::SEL_CNT;
    else if (addr == PRD_OFS) sel = tmr_pkg::SEL_PRD;
    else if (addr == CTL_OFS) sel = tmr_pkg::SEL_CTL;
    else                      sel = tmr_pkg::SEL_NONE;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             restart,
  input  logic [PSC_W-1:0] wr_div,
  input  logic [PSC_W-1:0] wr_psc,
  output logic [PSC_W-1:0] div_q,
  output logic [PSC_W-1:0] psc_q,
  output logic             tick
);
  logic [PSC_W-1:0] div_d, psc_d;
  logic             div_en, psc_en;

  always_comb begin
    div_d  = div_q;
    psc_d  = psc_q;
    div_en = 1'b0;
    psc_en = 1'b1;
    tick   = 1'b0;
    if (ctl_wr) begin
      div_en = 1'b1;
      div_d  = wr_div;
      psc_d  = restart ? wr_div : wr_psc;
    end else if (psc_q <= PSC_W'(1)) begin
      psc_d = div_q;
      tick  = 1'b1;
    end else begin
      psc_d = psc_q - PSC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      psc_q <= '0;
    end else begin
      if (div_en) div_q <= div_d;
      if (psc_en) psc_q <= psc_d;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             prd_wr,
  input  logic             restart,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] tim_q,
  output logic [CNT_W-1:0] prd_q,
  output logic             irq_q
);
  logic [CNT_W-1:0] tim_d;
  logic             tim_en, irq_d;

  always_comb begin
    tim_d  = tim_q;
    tim_en = 1'b0;
    irq_d  = 1'b0;
    if (cnt_wr) begin
      tim_en = 1'b1;
      tim_d  = wdata;
    end else if (restart) begin
      tim_en = 1'b1;
      tim_d  = prd_q;
    end else if (tick) begin
      tim_en = 1'b1;
      if (tim_q <= CNT_W'(1)) begin
        tim_d = prd_q;
        irq_d = 1'b1;
      end else begin
        tim_d = tim_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q <= '0;
      prd_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (tim_en) tim_q <= tim_d;
      if (prd_wr) prd_q <= wdata;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/pstimer.sv
module pstimer #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 4,
  parameter logic [ADDR_W-1:0] CNT_OFS = 'h24,
  parameter logic [ADDR_W-1:0] PRD_OFS = 'h25,
  parameter logic [ADDR_W-1:0] CTL_OFS = 'h26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import tmr_pkg::*;

  localparam int unsigned PSC_MSB = CTL_PSC_LSB + PSC_W - 1;
  localparam int unsigned DIV_MSB = CTL_DIV_LSB + PSC_W - 1;

  tmr_sel_e         sel;
  logic             cnt_wr, prd_wr, ctl_wr, restart, tick;
  logic [PSC_W-1:0] div_q, psc_q;
  logic [CNT_W-1:0] tim_q, prd_q;

  tmr_decode #(
    .ADDR_W(ADDR_W), .CNT_OFS(CNT_OFS), .PRD_OFS(PRD_OFS), .CTL_OFS(CTL_OFS)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  assign cnt_wr  = bus_wr && (sel == SEL_CNT);
  assign prd_wr  = bus_wr && (sel == SEL_PRD);
  assign ctl_wr  = bus_wr && (sel == SEL_CTL);
  assign restart = ctl_wr && bus_wdata[CTL_RLD_BIT];

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_wr (ctl_wr),
    .restart(restart),
    .wr_div (bus_wdata[DIV_MSB:CTL_DIV_LSB]),
    .wr_psc (bus_wdata[PSC_MSB:CTL_PSC_LSB]),
    .div_q  (div_q),
    .psc_q  (psc_q),
    .tick   (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .cnt_wr (cnt_wr),
    .prd_wr (prd_wr),
    .restart(restart),
    .wdata  (bus_wdata[CNT_W-1:0]),
    .tim_q  (tim_q),
    .prd_q  (prd_q),
    .irq_q  (irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_CNT: bus_rdata = DATA_W'(tim_q);
      SEL_PRD: bus_rdata = DATA_W'(prd_q);
      SEL_CTL: begin
        bus_rdata[DIV_MSB:CTL_DIV_LSB] = div_q;
        bus_rdata[PSC_MSB:CTL_PSC_LSB] = psc_q;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pstimer_chk.sv
module pstimer_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 4,
  parameter logic [ADDR_W-1:0] CNT_OFS = 'h24,
  parameter logic [ADDR_W-1:0] CTL_OFS = 'h26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  tim_q,
  input logic [CNT_W-1:0]  prd_q,
  input logic [PSC_W-1:0]  psc_q
);
  // R2
  psc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && psc_q > PSC_W'(1)) |=> (psc_q == $past(psc_q) - PSC_W'(1)));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && psc_q > PSC_W'(1)) |=> $stable(tim_q));

  // R4
  irq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tim_q == $past(prd_q)));

  // R6
  ctl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTL_OFS) |-> (bus_rdata[5:4] == 2'b00 && (bus_rdata >> (6 + PSC_W)) == '0));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTL_OFS && bus_wdata[5])
      |=> (tim_q == $past(prd_q) && psc_q == $past(bus_wdata[PSC_W-1:0]) && !irq));

  // R8
  cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CNT_OFS) |=> (tim_q == $past(bus_wdata[CNT_W-1:0]) && !irq));
endmodule

bind pstimer pstimer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W),
  .CNT_OFS(CNT_OFS), .CTL_OFS(CTL_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .tim_q(tim_q), .prd_q(prd_q), .psc_q(psc_q)
);

// File: tb/pstimer_bench.sv
module pstimer_bench;
  localparam logic [7:0] A_CNT = 8'h24;
  localparam logic [7:0] A_PRD = 8'h25;
  localparam logic [7:0] A_CTL = 8'h26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pstimer u_pstimer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_CNT, v); chk("R1 counter", v, 0);
    rd(A_PRD, v); chk("R1 period", v, 0);
    rd(A_CTL, v); chk("R1 control", v, 0);

    // R5 direct writes and readback
    wr(A_PRD, 16'hBEEF); rd(A_PRD, v); chk("R5 period write", v, 16'hBEEF);
    wr(A_CNT, 16'h1234); rd(A_CNT, v); chk("R5 counter write", v, 16'h1234);

    // R6 control fields: div=5, psc=15, restart clear
    wr(A_CTL, 16'h03C5); rd(A_CTL, v); chk("R6 control readback", v, 16'h03C5);
    @(negedge clk); rd(A_CTL, v); chk("R2 live prescaler step", v, 16'h0385);

    // R6/R7 all ones: restart bit and reserved bits read 0, psc = div = 15
    wr(A_PRD, 16'h0100);
    wr(A_CTL, 16'hFFFF); rd(A_CTL, v); chk("R6 R7 restart read 0", v, 16'h03CF);
    rd(A_CNT, v); chk("R7 counter from period", v, 16'h0100);

    // R2/R3 stepping with period 7, divide 2
    wr(A_PRD, 16'd7);
    wr(A_CTL, 16'h0022);
    for (int k = 0; k < 10; k++) begin
      rd(A_CTL, v); chk("R2 prescaler count", v, ((2 - (k % 2)) << 6) | 2);
      rd(A_CNT, v); chk("R3 counter value", v, 7 - k / 2);
      chk("R4 no irq mid-interval", int'(irq), 0);
      @(negedge clk);
    end

    // R8 counter write beats a pending reload
    wr(A_PRD, 16'd0);
    wr(A_CTL, 16'h0020);
    @(negedge clk); chk("R4 irq every cycle at zero config", int'(irq), 1);
    wr(A_CNT, 16'd3);
    chk("R8 no irq on counter write", int'(irq), 0);
    rd(A_CNT, v); chk("R8 counter holds written value", v, 3);
    @(negedge clk); chk("R8 irq k1", int'(irq), 0);
    @(negedge clk); chk("R8 irq k2", int'(irq), 0);
    @(negedge clk); chk("R8 irq at reload", int'(irq), 1);

    // R6 unmapped addresses
    wr(A_PRD, 16'h0055);
    wr(A_CTL, 16'h0023);
    wr(8'h27, 16'hFFFF);
    wr(8'h23, 16'hFFFF);
    rd(8'h23, v); chk("R6 unmapped read", v, 0);
    rd(A_PRD, v); chk("R6 unmapped write period", v, 16'h0055);
    rd(A_CTL, v); chk("R6 unmapped write divide", v & 16'h000F, 3);

    // R4 sweep over divide and period
    for (int d = 0; d <= 4; d++) begin
      for (int p = 0; p <= 5; p++) begin
        int n;
        n = (d < 1 ? 1 : d) * (p < 1 ? 1 : p);
        wr(A_PRD, 16'(p));
        wr(A_CTL, 16'(d) | 16'h0020);
        chk("R7 no irq on restart", int'(irq), 0);
        for (int k = 1; k <= 2 * n; k++) begin
          @(negedge clk);
          chk($sformatf("R4 irq d=%0d p=%0d k=%0d", d, p, k), int'(irq),
              (k % n == 0) ? 1 : 0);
        end
      end
    end

    done = 1;
    summary();
  end
endmodule